// File: doc/BRIEF.md
# Free-Running 64-bit Counter with Self-Reloading Comparator

This block is a memory-mapped timer. A 64-bit up-counter advances by one on every clock while it is started. One 64-bit comparator watches the counter. On a match it raises a sticky interrupt status bit. The comparator then either stays where it is (single-shot) or advances itself by a programmable 32-bit step, so the next match comes one step later (periodic). A single level interrupt output reports a pending match while the matching enable bit is set.

Software reaches everything through a plain 32-bit register bus with a single address, a write strobe and a combinational read port. The register offsets are fixed because drivers decode them. The counter is exposed as two live words, so a reader can read high, then low, then high again, and retry when the two high reads differ.

Each write to a tracked register is confirmed later by a sticky acknowledge bit. That bit appears a fixed, parameterised number of cycles after the write, which models the time a slower timer domain would take to apply the value. Software clears an acknowledge bit by writing 1 to it.

Top module: `ctr64_cmp_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `irq_o` is low.
- R2: While control bit 8 (offset 0x240) is 1 the counter advances by exactly one per clock. While that bit is 0 the counter holds its value.
- R3: A write to offset 0x100 loads the low counter word and a write to 0x104 loads the high word. A write takes priority over counting in the same cycle. Reads of 0x104 show the carry out of the low word in the cycle the low word wraps from 0xFFFFFFFF to 0.
- R4: A match occurs when control bit 0 is 1, the counter is running and the counter equals the comparator (0x200 low, 0x204 high). A match sets interrupt status bit 0 (0x244) at the next clock edge.
- R5: With control bit 1 at 0, a match leaves the comparator unchanged, so a running counter matches only once.
- R6: With control bit 1 at 1, each match adds the 32-bit step register (0x208), zero-extended, to the comparator. A comparator write in the same cycle wins over the addition.
- R7: Writing 1 to bit 0 of 0x244 clears interrupt status. Writing 0 has no effect. A match in the same cycle as the clear leaves the status set.
- R8: `irq_o` is high exactly while interrupt enable bit 0 (0x248) and interrupt status bit 0 are both 1.
- R9: A write to a tracked register sets its acknowledge bit exactly ACK_LAT cycles after the write edge. The bits are: control → bit 16 of 0x24C, comparator low → bit 0, comparator high → bit 1, step → bit 2, counter low → bit 0 of 0x110, counter high → bit 1 of 0x110. Writing 1 to an acknowledge bit clears it, and writing 0 leaves it. A new acknowledge in the same cycle wins over the clear.
- R10: Clearing control bit 0 stops all further matches but leaves a pending interrupt status set.
- R11: Control reads back only bits 8, 1 and 0, with every other bit zero. Unmapped offsets read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset for the read and write |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Level interrupt |

## Verification
Assertions check on every cycle that the counter steps by one or holds, and that the low-word wrap carries into the high word. They also check that a single-shot match keeps the comparator and a periodic match adds the step, that a match always leaves the status set, that a clear without a match empties it, and that an acknowledge bit only rises from the end of its latency pipeline. Only the bench scenarios can show the exact cycle in which an acknowledge appears, and the behaviour of the register map as a whole. They also cover the read-back masks, the ignored writes, the race between a clear and a match, and status being kept after the comparator is switched off. The bench covers these through a behavioural model that is compared on every clock.

// File: rtl/ctr64_cmp_pkg.sv
package ctr64_cmp_pkg;

   // register offsets (decoded by software, kept fixed)
   localparam logic [11:0] OFS_CNT_LO  = 12'h100;
   localparam logic [11:0] OFS_CNT_HI  = 12'h104;
   localparam logic [11:0] OFS_CNT_ACK = 12'h110;
   localparam logic [11:0] OFS_CMP_LO  = 12'h200;
   localparam logic [11:0] OFS_CMP_HI  = 12'h204;
   localparam logic [11:0] OFS_STEP    = 12'h208;
   localparam logic [11:0] OFS_CTRL    = 12'h240;
   localparam logic [11:0] OFS_IRQ_ST  = 12'h244;
   localparam logic [11:0] OFS_IRQ_EN  = 12'h248;
   localparam logic [11:0] OFS_ACK     = 12'h24C;

   // control bit positions
   localparam int CTL_CMP_EN = 0;
   localparam int CTL_AUTO   = 1;
   localparam int CTL_RUN    = 8;

   // acknowledge bit positions
   localparam int ACKB_CMP_LO = 0;
   localparam int ACKB_CMP_HI = 1;
   localparam int ACKB_STEP   = 2;
   localparam int ACKB_CTRL   = 16;
   localparam int ACKB_CNT_LO = 0;
   localparam int ACKB_CNT_HI = 1;

   // tracked-write indices inside the acknowledge unit
   localparam int TRK_CNT_LO = 0;
   localparam int TRK_CNT_HI = 1;
   localparam int TRK_CMP_LO = 2;
   localparam int TRK_CMP_HI = 3;
   localparam int TRK_STEP   = 4;
   localparam int TRK_CTRL   = 5;
   localparam int N_TRK      = 6;

   typedef struct packed {
      logic run;
      logic auto_inc;
      logic cmp_en;
   } ctl_t;

endpackage

// File: rtl/ctr64_counter.sv
module ctr64_counter #(
   parameter int unsigned HALF_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                ld_lo,
   input  logic                ld_hi,
   input  logic [HALF_W-1:0]   wdata,
   output logic [2*HALF_W-1:0] cnt
);
   localparam int unsigned FULL_W = 2 * HALF_W;

   if (HALF_W < 8) begin : g_bad_width
      $error("ctr64_counter: HALF_W must be at least 8");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (ld_lo) begin
         cnt <= {cnt[FULL_W-1:HALF_W], wdata};
      end else if (ld_hi) begin
         cnt <= {wdata, cnt[HALF_W-1:0]};
      end else if (run) begin
         cnt <= cnt + FULL_W'(1);
      end
   end

   a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ld_lo && !ld_hi) |=> cnt == $past(cnt) + FULL_W'(1));

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ld_lo && !ld_hi) |=> $stable(cnt));

   a_r3_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ld_lo && !ld_hi && (&cnt[HALF_W-1:0]))
      |=> cnt[FULL_W-1:HALF_W] == $past(cnt[FULL_W-1:HALF_W]) + HALF_W'(1));

endmodule

// File: rtl/ctr64_comparator.sv
module ctr64_comparator #(
   parameter int unsigned HALF_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*HALF_W-1:0] cnt,
   input  logic                run,
   input  logic                cmp_en,
   input  logic                auto_inc,
   input  logic                ld_lo,
   input  logic                ld_hi,
   input  logic                ld_step,
   input  logic [HALF_W-1:0]   wdata,
   output logic [2*HALF_W-1:0] cmp_val,
   output logic [HALF_W-1:0]   step_val,
   output logic                hit
);
   localparam int unsigned FULL_W = 2 * HALF_W;

   logic [FULL_W-1:0] step_ext;
   assign step_ext = {{(FULL_W-HALF_W){1'b0}}, step_val};
   assign hit      = cmp_en && run && (cnt == cmp_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_val <= '0;
      end else if (ld_lo) begin
         cmp_val <= {cmp_val[FULL_W-1:HALF_W], wdata};
      end else if (ld_hi) begin
         cmp_val <= {wdata, cmp_val[HALF_W-1:0]};
      end else if (hit && auto_inc) begin
         cmp_val <= cmp_val + step_ext;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       step_val <= '0;
      else if (ld_step) step_val <= wdata;
   end

   a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && auto_inc && !ld_lo && !ld_hi)
      |=> cmp_val == $past(cmp_val) + {{(FULL_W-HALF_W){1'b0}}, $past(step_val)});

   a_r5_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !auto_inc && !ld_lo && !ld_hi) |=> $stable(cmp_val));

endmodule

// File: rtl/ctr64_write_ack.sv
module ctr64_write_ack #(
   parameter int unsigned N   = 6,
   parameter int unsigned LAT = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] wr_pulse,
   input  logic [N-1:0] clr,
   output logic [N-1:0] status
);
   if (LAT < 1 || LAT > 16) begin : g_bad_lat
      $error("ctr64_write_ack: LAT must lie in 1..16");
   end

   logic [N-1:0] tail;

   if (LAT == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tail <= '0;
         else        tail <= wr_pulse;
      end
   end else begin : g_chain
      logic [LAT-1:0][N-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= '0;
         else        pipe <= {pipe[LAT-2:0], wr_pulse};
      end
      assign tail = pipe[LAT-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~clr) | tail;
   end

   for (genvar i = 0; i < N; i++) begin : g_chk
      a_r9_rise_from_pipe: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(status[i]) |-> $past(tail[i]));
      a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !tail[i]) |=> !status[i]);
   end

endmodule

// File: rtl/ctr64_cmp_timer.sv
module ctr64_cmp_timer
   import ctr64_cmp_pkg::*;
#(
   parameter int unsigned BUS_W   = 32,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned ACK_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq_o
);
   localparam int unsigned CNT_W = 2 * BUS_W;

   if (BUS_W < 17) begin : g_bad_bus
      $error("ctr64_cmp_timer: BUS_W must hold bit 16");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ctr64_cmp_timer: ADDR_W must cover offset 0x24C");
   end

   function automatic logic at_ofs(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   // write decode
   logic wr_cnt_lo, wr_cnt_hi, wr_cnt_ack, wr_cmp_lo, wr_cmp_hi, wr_step;
   logic wr_ctrl, wr_ist, wr_ien, wr_ack;
   assign wr_cnt_lo  = bus_wen && at_ofs(bus_addr, OFS_CNT_LO);
   assign wr_cnt_hi  = bus_wen && at_ofs(bus_addr, OFS_CNT_HI);
   assign wr_cnt_ack = bus_wen && at_ofs(bus_addr, OFS_CNT_ACK);
   assign wr_cmp_lo  = bus_wen && at_ofs(bus_addr, OFS_CMP_LO);
   assign wr_cmp_hi  = bus_wen && at_ofs(bus_addr, OFS_CMP_HI);
   assign wr_step    = bus_wen && at_ofs(bus_addr, OFS_STEP);
   assign wr_ctrl    = bus_wen && at_ofs(bus_addr, OFS_CTRL);
   assign wr_ist     = bus_wen && at_ofs(bus_addr, OFS_IRQ_ST);
   assign wr_ien     = bus_wen && at_ofs(bus_addr, OFS_IRQ_EN);
   assign wr_ack     = bus_wen && at_ofs(bus_addr, OFS_ACK);

   // control
   ctl_t ctl;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (wr_ctrl) begin
         ctl.run      <= bus_wdata[CTL_RUN];
         ctl.auto_inc <= bus_wdata[CTL_AUTO];
         ctl.cmp_en   <= bus_wdata[CTL_CMP_EN];
      end
   end

   // counter and comparator
   logic [CNT_W-1:0] cnt, cmp_val;
   logic [BUS_W-1:0] step_val;
   logic             hit;

   ctr64_counter #(.HALF_W(BUS_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctl.run),
      .ld_lo (wr_cnt_lo),
      .ld_hi (wr_cnt_hi),
      .wdata (bus_wdata),
      .cnt   (cnt)
   );

   ctr64_comparator #(.HALF_W(BUS_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt),
      .run      (ctl.run),
      .cmp_en   (ctl.cmp_en),
      .auto_inc (ctl.auto_inc),
      .ld_lo    (wr_cmp_lo),
      .ld_hi    (wr_cmp_hi),
      .ld_step  (wr_step),
      .wdata    (bus_wdata),
      .cmp_val  (cmp_val),
      .step_val (step_val),
      .hit      (hit)
   );

   // interrupt status and enable
   logic irq_st, irq_en;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        irq_st <= 1'b0;
      else if (hit)                      irq_st <= 1'b1;
      else if (wr_ist && bus_wdata[0])   irq_st <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      irq_en <= 1'b0;
      else if (wr_ien) irq_en <= bus_wdata[0];
   end

   assign irq_o = irq_en && irq_st;

   // write acknowledge tracking
   logic [N_TRK-1:0] trk_set, trk_clr, trk_st;
   assign trk_set[TRK_CNT_LO] = wr_cnt_lo;
   assign trk_set[TRK_CNT_HI] = wr_cnt_hi;
   assign trk_set[TRK_CMP_LO] = wr_cmp_lo;
   assign trk_set[TRK_CMP_HI] = wr_cmp_hi;
   assign trk_set[TRK_STEP]   = wr_step;
   assign trk_set[TRK_CTRL]   = wr_ctrl;

   assign trk_clr[TRK_CNT_LO] = wr_cnt_ack && bus_wdata[ACKB_CNT_LO];
   assign trk_clr[TRK_CNT_HI] = wr_cnt_ack && bus_wdata[ACKB_CNT_HI];
   assign trk_clr[TRK_CMP_LO] = wr_ack && bus_wdata[ACKB_CMP_LO];
   assign trk_clr[TRK_CMP_HI] = wr_ack && bus_wdata[ACKB_CMP_HI];
   assign trk_clr[TRK_STEP]   = wr_ack && bus_wdata[ACKB_STEP];
   assign trk_clr[TRK_CTRL]   = wr_ack && bus_wdata[ACKB_CTRL];

   ctr64_write_ack #(.N(N_TRK), .LAT(ACK_LAT)) u_ack (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_pulse (trk_set),
      .clr      (trk_clr),
      .status   (trk_st)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (at_ofs(bus_addr, OFS_CNT_LO)) begin
         bus_rdata = cnt[BUS_W-1:0];
      end else if (at_ofs(bus_addr, OFS_CNT_HI)) begin
         bus_rdata = cnt[CNT_W-1:BUS_W];
      end else if (at_ofs(bus_addr, OFS_CNT_ACK)) begin
         bus_rdata[ACKB_CNT_LO] = trk_st[TRK_CNT_LO];
         bus_rdata[ACKB_CNT_HI] = trk_st[TRK_CNT_HI];
      end else if (at_ofs(bus_addr, OFS_CMP_LO)) begin
         bus_rdata = cmp_val[BUS_W-1:0];
      end else if (at_ofs(bus_addr, OFS_CMP_HI)) begin
         bus_rdata = cmp_val[CNT_W-1:BUS_W];
      end else if (at_ofs(bus_addr, OFS_STEP)) begin
         bus_rdata = step_val;
      end else if (at_ofs(bus_addr, OFS_CTRL)) begin
         bus_rdata[CTL_RUN]    = ctl.run;
         bus_rdata[CTL_AUTO]   = ctl.auto_inc;
         bus_rdata[CTL_CMP_EN] = ctl.cmp_en;
      end else if (at_ofs(bus_addr, OFS_IRQ_ST)) begin
         bus_rdata[0] = irq_st;
      end else if (at_ofs(bus_addr, OFS_IRQ_EN)) begin
         bus_rdata[0] = irq_en;
      end else if (at_ofs(bus_addr, OFS_ACK)) begin
         bus_rdata[ACKB_CMP_LO] = trk_st[TRK_CMP_LO];
         bus_rdata[ACKB_CMP_HI] = trk_st[TRK_CMP_HI];
         bus_rdata[ACKB_STEP]   = trk_st[TRK_STEP];
         bus_rdata[ACKB_CTRL]   = trk_st[TRK_CTRL];
      end
   end

   a_r4_hit_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> irq_st);

   a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ist && bus_wdata[0] && !hit) |=> !irq_st);

   a_r10_status_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_st && !(wr_ist && bus_wdata[0])) |=> irq_st);

   a_r8_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> (irq_st && irq_en));

endmodule

// File: tb/ctr64_cmp_timer_tb.sv
module ctr64_cmp_timer_tb;
   localparam int BUS_W   = 32;
   localparam int ADDR_W  = 12;
   localparam int ACK_LAT = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_wen = 1'b0;
   logic [BUS_W-1:0]  bus_wdata = '0;
   logic [BUS_W-1:0]  bus_rdata;
   logic              irq_o;

   always #4 clk = ~clk;   // 125 MHz

   ctr64_cmp_timer #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .ACK_LAT(ACK_LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // behavioural reference model
   longint unsigned m_cnt, m_cmp;
   bit [31:0]       m_step;
   bit              m_run, m_auto, m_en, m_ist, m_ien;
   bit [5:0]        m_ack;   // 0 cnt lo,1 cnt hi,2 cmp lo,3 cmp hi,4 step,5 ctrl
   int              cyc;
   int              due_q[$];
   int              idx_q[$];

   always @(posedge clk) begin
      bit        w, hit;
      bit [11:0] a;
      bit [31:0] d;
      int        trk;
      if (!rst_n) begin
         m_cnt = 0; m_cmp = 0; m_step = 0;
         m_run = 0; m_auto = 0; m_en = 0; m_ist = 0; m_ien = 0;
         m_ack = 0; cyc = 0;
         due_q.delete(); idx_q.delete();
      end else begin
         w = bus_wen; a = bus_addr; d = bus_wdata;
         hit = m_en && m_run && (m_cnt == m_cmp);
         cyc++;
         if (w && a == 12'h100)      m_cnt = {m_cnt[63:32], d};
         else if (w && a == 12'h104) m_cnt = {d, m_cnt[31:0]};
         else if (m_run)             m_cnt = m_cnt + 1;
         if (w && a == 12'h200)      m_cmp = {m_cmp[63:32], d};
         else if (w && a == 12'h204) m_cmp = {d, m_cmp[31:0]};
         else if (hit && m_auto)     m_cmp = m_cmp + {32'h0, m_step};
         if (w && a == 12'h208) m_step = d;
         if (w && a == 12'h240) begin
            m_run = d[8]; m_auto = d[1]; m_en = d[0];
         end
         if (hit)                         m_ist = 1;
         else if (w && a == 12'h244 && d[0]) m_ist = 0;
         if (w && a == 12'h248) m_ien = d[0];
         if (w && a == 12'h110) begin
            if (d[0]) m_ack[0] = 0;
            if (d[1]) m_ack[1] = 0;
         end
         if (w && a == 12'h24C) begin
            if (d[0])  m_ack[2] = 0;
            if (d[1])  m_ack[3] = 0;
            if (d[2])  m_ack[4] = 0;
            if (d[16]) m_ack[5] = 0;
         end
         while (due_q.size() > 0 && due_q[0] == cyc) begin
            m_ack[idx_q[0]] = 1;
            void'(due_q.pop_front());
            void'(idx_q.pop_front());
         end
         trk = -1;
         if (w) begin
            case (a)
               12'h100: trk = 0;
               12'h104: trk = 1;
               12'h200: trk = 2;
               12'h204: trk = 3;
               12'h208: trk = 4;
               12'h240: trk = 5;
               default: trk = -1;
            endcase
         end
         if (trk >= 0) begin
            due_q.push_back(cyc + ACK_LAT);
            idx_q.push_back(trk);
         end
      end
   end

   function automatic bit [31:0] model_read(input bit [11:0] a);
      bit [31:0] r;
      r = 0;
      case (a)
         12'h100: r = m_cnt[31:0];
         12'h104: r = m_cnt[63:32];
         12'h110: begin r[0] = m_ack[0]; r[1] = m_ack[1]; end
         12'h200: r = m_cmp[31:0];
         12'h204: r = m_cmp[63:32];
         12'h208: r = m_step;
         12'h240: begin r[8] = m_run; r[1] = m_auto; r[0] = m_en; end
         12'h244: r[0] = m_ist;
         12'h248: r[0] = m_ien;
         12'h24C: begin
            r[0] = m_ack[2]; r[1] = m_ack[3]; r[2] = m_ack[4]; r[16] = m_ack[5];
         end
         default: r = 0;
      endcase
      return r;
   endfunction

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      bit [31:0] er;
      bit        ei;
      if (rst_n && !done) begin
         er = model_read(bus_addr);
         ei = m_ien && m_ist;
         n_cmp++;
         if (bus_rdata !== er) begin
            n_bad++;
            $display("FAIL %s rdata @%h: got %h expected %h", cur_req, bus_addr, bus_rdata, er);
         end
         n_cmp++;
         if (irq_o !== ei) begin
            n_bad++;
            $display("FAIL %s irq_o: got %b expected %b", cur_req, irq_o, ei);
         end
      end
   end

   task automatic wr(input bit [11:0] a, input bit [31:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(posedge clk); #1;
      bus_wen = 1'b0;
   endtask

   task automatic watch(input bit [11:0] a, input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         bus_addr = a; bus_wen = 1'b0;
      end
   endtask

   initial begin
      #(8 * 100000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      cur_req = "R1";
      foreach (model_addrs[i]) watch(model_addrs[i], 2);

      cur_req = "R11";
      wr(12'h240, 32'hFFFF_FEFC);
      watch(12'h240, 2);
      wr(12'h300, 32'hFFFF_FFFF);
      watch(12'h300, 2);
      watch(12'h100, 2);

      cur_req = "R9";
      watch(12'h24C, 5);
      wr(12'h24C, 32'h0);
      watch(12'h24C, 2);
      wr(12'h24C, 32'h0001_0000);
      watch(12'h24C, 3);

      cur_req = "R2";
      wr(12'h240, 32'h100);
      watch(12'h100, 10);
      wr(12'h240, 32'h0);
      watch(12'h100, 6);

      cur_req = "R3";
      wr(12'h100, 32'hFFFF_FFF0);
      wr(12'h104, 32'h5);
      watch(12'h110, 5);
      wr(12'h110, 32'h3);
      watch(12'h110, 3);
      wr(12'h240, 32'h100);
      watch(12'h104, 25);
      watch(12'h100, 3);

      cur_req = "R4";
      wr(12'h240, 32'h0);
      wr(12'h100, 32'h0);
      wr(12'h104, 32'h0);
      wr(12'h200, 32'd40);
      wr(12'h204, 32'h0);
      wr(12'h248, 32'h1);
      wr(12'h240, 32'h101);
      watch(12'h244, 50);

      cur_req = "R8";
      wr(12'h248, 32'h0);
      watch(12'h244, 3);
      wr(12'h248, 32'h1);
      watch(12'h244, 2);

      cur_req = "R5";
      watch(12'h200, 3);
      wr(12'h244, 32'h1);
      watch(12'h244, 20);

      cur_req = "R7";
      wr(12'h244, 32'h0);
      watch(12'h244, 2);

      cur_req = "R6";
      wr(12'h240, 32'h0);
      wr(12'h100, 32'h0);
      wr(12'h200, 32'd10);
      wr(12'h208, 32'd7);
      wr(12'h240, 32'h103);
      watch(12'h200, 40);
      wr(12'h204, 32'h0);
      watch(12'h204, 3);

      cur_req = "R7";
      for (int i = 0; i < 20; i++) wr(12'h244, 32'h1);
      watch(12'h244, 12);

      cur_req = "R10";
      wr(12'h240, 32'h100);
      watch(12'h244, 30);
      wr(12'h244, 32'h1);
      watch(12'h244, 20);
      watch(12'h200, 3);

      cur_req = "R9";
      watch(12'h24C, 2);
      wr(12'h24C, 32'h0001_0007);
      watch(12'h24C, 2);
      wr(12'h110, 32'h0000_0003);
      watch(12'h110, 2);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   bit [11:0] model_addrs [10] = '{12'h100, 12'h104, 12'h110, 12'h200, 12'h204,
                                   12'h208, 12'h240, 12'h244, 12'h248, 12'h24C};

endmodule